// File: doc/BRIEF.md
# JTAG Serial Port Byte Exchanger

This block carries a character terminal between a debug host and the target over a debug data-register scan path. A TAP controller outside the block supplies Capture-DR, Shift-DR and Update-DR strobes as single-cycle enables in the block's clock domain, along with a module-enable input that is high while this channel is the selected debug module. Each scan is one fixed 72-bit frame: a header byte, then eight byte slots. In one frame the host delivers up to eight characters and collects up to eight.

Two 8-entry FIFOs buffer the traffic. One holds characters from the host that are waiting for the target. The other holds characters from the target that are waiting for the host. The target side sees two valid/ready byte streams. Returned characters leave their FIFO only when a complete frame reaches Update-DR, so a scan that is abandoned loses nothing.

A three-state machine sequences the scan. In Idle it waits for Capture-DR. Capture-DR moves it to Shift. The 72nd shift bit moves it from Shift to Done, and Done ignores any further shift bits. Update-DR from Done commits the frame and returns to Idle. Update-DR from Shift returns to Idle and commits nothing. Capture-DR from any state restarts in Shift. FIFO depth must be a power of two, and at most 15 slots are allowed.

Top module: `jtag_char_xchg`

## Requirements
- R1: At Capture-DR the header byte is loaded. Bits 7:4 hold min(bytes waiting for the host, 8). Bits 3:0 hold min(free entries in the host-to-target FIFO, 8).
- R2: After the header, the returned slots hold the oldest waiting characters, oldest first. Each byte goes out least significant bit first. Slots beyond the returned count read as zero.
- R3: In the received frame, header bits 7:4 give the host's byte count. At a committed Update-DR, min(that count, the free count captured for this frame) bytes are appended to the host-to-target FIFO in slot order. Counts of 9 to 15 are clamped the same way.
- R4: Characters leave the target-to-host FIFO only at Update-DR after all 72 bits have been shifted. An Update-DR that arrives earlier changes neither FIFO.
- R5: Shift bits beyond the 72nd are ignored.
- R6: While the module-enable input is low, the scan strobes have no effect on either FIFO.
- R7: rx_valid is high when the host-to-target FIFO is not empty, and rx_data shows its head. A byte moves when rx_valid and rx_ready are both high. tx_ready is low only when the target-to-host FIFO is full, and a byte is accepted when tx_valid and tx_ready are both high.
- R8: A synchronous reset empties both FIFOs and returns the scan sequencer to Idle.
- R9: Neither FIFO count ever exceeds its depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan and target clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Module enable; strobes count only while high |
| cap_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe, one bit per cycle |
| upd_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data from the host |
| tdo | output | 1 | Serial data to the host |
| tx_valid | input | 1 | Target offers a character for the host |
| tx_ready | output | 1 | Block can accept a character from the target |
| tx_data | input | 8 | Character from the target |
| rx_valid | output | 1 | Character from the host is available |
| rx_ready | input | 1 | Target takes the offered character |
| rx_data | output | 8 | Character for the target |

## Verification
The checker assumes that Capture-DR, Shift-DR and Update-DR are never asserted in the same cycle, as they would be from a TAP state machine. The bench drives each strobe alone, one per cycle. The assertions also assume that the target keeps tx_valid and tx_data meaningful only while it intends to send, and the bench honours this by checking tx_ready before it records a push. Frames are always 72 bits, except in the deliberate early-update and trailing-bit cases, which stay within the exclusive-strobe rule.

// File: rtl/jcx_pkg.sv
package jcx_pkg;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_DONE
    } scan_state_e;
endpackage

// File: rtl/jcx_fifo.sv
module jcx_fifo
    import jcx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SLOTS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NIB_W-1:0]           push_n,
    input  logic [SLOTS*BYTE_W-1:0]    push_data,
    input  logic [NIB_W-1:0]           pop_n,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [SLOTS*BYTE_W-1:0]    peek
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_q, rd_q;
    logic [CW-1:0]     cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (NIB_W'(i) < push_n)
                    mem[wr_q + AW'(i)] <= push_data[i*BYTE_W +: BYTE_W];
            end
            wr_q  <= wr_q + AW'(push_n);
            rd_q  <= rd_q + AW'(pop_n);
            cnt_q <= cnt_q + CW'(push_n) - CW'(pop_n);
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_peek
        assign peek[g*BYTE_W +: BYTE_W] = mem[rd_q + AW'(g)];
    end

    assign count = cnt_q;
endmodule

// File: rtl/jcx_scan.sv
module jcx_scan
    import jcx_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sel,
    input  logic                    cap_dr,
    input  logic                    shift_dr,
    input  logic                    upd_dr,
    input  logic                    tdi,
    output logic                    tdo,
    input  logic [NIB_W-1:0]        ret_n,
    input  logic [NIB_W-1:0]        free_n,
    input  logic [SLOTS*BYTE_W-1:0] ret_data,
    output logic                    commit,
    output logic [NIB_W-1:0]        give_n,
    output logic [NIB_W-1:0]        take_n,
    output logic [SLOTS*BYTE_W-1:0] rx_bytes
);
    localparam int LEN = BYTE_W * (SLOTS + 1);
    localparam int BW  = $clog2(LEN + 1);

    scan_state_e             st_q, st_d;
    logic [LEN-1:0]          sr_q;
    logic [BW-1:0]           bits_q;
    logic [NIB_W-1:0]        cap_ret_q, cap_free_q;
    logic [SLOTS*BYTE_W-1:0] masked;
    logic [NIB_W-1:0]        hdr_cnt;

    for (genvar g = 0; g < SLOTS; g++) begin : g_mask
        assign masked[g*BYTE_W +: BYTE_W] =
            (NIB_W'(g) < ret_n) ? ret_data[g*BYTE_W +: BYTE_W] : '0;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (sel && cap_dr) st_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (sel && cap_dr)      st_d = ST_SHIFT;
                else if (sel && upd_dr) st_d = ST_IDLE;
                else if (sel && shift_dr && bits_q == BW'(LEN - 1))
                    st_d = ST_DONE;
            end
            ST_DONE: begin
                if (sel && cap_dr)      st_d = ST_SHIFT;
                else if (sel && upd_dr) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        hdr_cnt  = sr_q[BYTE_W-1 -: NIB_W];
        commit   = (st_q == ST_DONE) && sel && upd_dr && !cap_dr;
        give_n   = cap_ret_q;
        take_n   = (hdr_cnt > cap_free_q) ? cap_free_q : hdr_cnt;
        rx_bytes = sr_q[LEN-1:BYTE_W];
        tdo      = sr_q[0];
    end

    // shift path
    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q       <= '0;
            bits_q     <= '0;
            cap_ret_q  <= '0;
            cap_free_q <= '0;
        end else if (sel && cap_dr) begin
            sr_q       <= {masked, ret_n, free_n};
            bits_q     <= '0;
            cap_ret_q  <= ret_n;
            cap_free_q <= free_n;
        end else if (sel && shift_dr && st_q == ST_SHIFT) begin
            sr_q   <= {tdi, sr_q[LEN-1:1]};
            bits_q <= bits_q + 1'b1;
        end
    end
endmodule

// File: rtl/jtag_char_xchg.sv
module jtag_char_xchg
    import jcx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SLOTS = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sel,
    input  logic        cap_dr,
    input  logic        shift_dr,
    input  logic        upd_dr,
    input  logic        tdi,
    output logic        tdo,
    input  logic        tx_valid,
    output logic        tx_ready,
    input  logic [7:0]  tx_data,
    output logic        rx_valid,
    input  logic        rx_ready,
    output logic [7:0]  rx_data
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int DW = SLOTS * BYTE_W;

    logic [CW-1:0]    h2t_cnt, t2h_cnt;
    logic [DW-1:0]    h2t_peek, t2h_peek, rx_bytes;
    logic [NIB_W-1:0] ret_n, free_n, give_n, take_n;
    logic [NIB_W-1:0] h2t_push_n, h2t_pop_n, t2h_push_n, t2h_pop_n;
    logic             commit;

    always_comb begin
        ret_n  = (int'(t2h_cnt) > SLOTS) ? NIB_W'(SLOTS) : NIB_W'(t2h_cnt);
        free_n = ((DEPTH - int'(h2t_cnt)) > SLOTS) ? NIB_W'(SLOTS)
                                                   : NIB_W'(DEPTH - int'(h2t_cnt));
        rx_valid   = (h2t_cnt != '0);
        rx_data    = h2t_peek[BYTE_W-1:0];
        tx_ready   = (t2h_cnt != CW'(DEPTH));
        h2t_push_n = commit ? take_n : '0;
        h2t_pop_n  = (rx_valid && rx_ready) ? NIB_W'(1) : '0;
        t2h_push_n = (tx_valid && tx_ready) ? NIB_W'(1) : '0;
        t2h_pop_n  = commit ? give_n : '0;
    end

    jcx_scan #(.SLOTS(SLOTS)) i_scan (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .cap_dr   (cap_dr),
        .shift_dr (shift_dr),
        .upd_dr   (upd_dr),
        .tdi      (tdi),
        .tdo      (tdo),
        .ret_n    (ret_n),
        .free_n   (free_n),
        .ret_data (t2h_peek),
        .commit   (commit),
        .give_n   (give_n),
        .take_n   (take_n),
        .rx_bytes (rx_bytes)
    );

    jcx_fifo #(.DEPTH(DEPTH), .SLOTS(SLOTS)) i_h2t (
        .clk       (clk),
        .rst       (rst),
        .push_n    (h2t_push_n),
        .push_data (rx_bytes),
        .pop_n     (h2t_pop_n),
        .count     (h2t_cnt),
        .peek      (h2t_peek)
    );

    jcx_fifo #(.DEPTH(DEPTH), .SLOTS(SLOTS)) i_t2h (
        .clk       (clk),
        .rst       (rst),
        .push_n    (t2h_push_n),
        .push_data (DW'(tx_data)),
        .pop_n     (t2h_pop_n),
        .count     (t2h_cnt),
        .peek      (t2h_peek)
    );
endmodule

// File: rtl/jtag_char_xchg_chk.sv
module jtag_char_xchg_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          sel,
    input logic          cap_dr,
    input logic          shift_dr,
    input logic          upd_dr,
    input logic          tx_ready,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic [7:0]    rx_data,
    input logic [CW-1:0] h2t_cnt,
    input logic [CW-1:0] t2h_cnt
);
    a_r9_h2t_bound: assert property (@(posedge clk) disable iff (rst)
        h2t_cnt <= CW'(DEPTH));

    a_r9_t2h_bound: assert property (@(posedge clk) disable iff (rst)
        t2h_cnt <= CW'(DEPTH));

    a_r7_rx_hold: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

    a_r7_full_blocks: assert property (@(posedge clk) disable iff (rst)
        t2h_cnt == CW'(DEPTH) |-> !tx_ready);

    a_r4_pop_only_at_update: assert property (@(posedge clk) disable iff (rst)
        !(sel && upd_dr) |=> t2h_cnt >= $past(t2h_cnt));

    a_r6_idle_no_push: assert property (@(posedge clk) disable iff (rst)
        !sel |=> h2t_cnt <= $past(h2t_cnt));

    a_r6_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cap_dr, shift_dr, upd_dr}));

    a_r8_reset_empties: assert property (@(posedge clk)
        rst |=> h2t_cnt == '0 && t2h_cnt == '0);
endmodule

bind jtag_char_xchg jtag_char_xchg_chk #(.DEPTH(DEPTH), .CW(CW)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .cap_dr   (cap_dr),
    .shift_dr (shift_dr),
    .upd_dr   (upd_dr),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .h2t_cnt  (h2t_cnt),
    .t2h_cnt  (t2h_cnt)
);

// File: tb/test_jtag_char_xchg.sv
`timescale 1ns/1ps
module test_jtag_char_xchg;
    logic clk = 0, rst = 1, sel = 1, cap_dr = 0, shift_dr = 0, upd_dr = 0, tdi = 0;
    logic tx_valid = 0, rx_ready = 0;
    logic [7:0] tx_data = 0;
    logic tdo, tx_ready, rx_valid;
    logic [7:0] rx_data;

    int total = 0, bad = 0;
    bit done = 0;
    logic [7:0] t2h_q[$];
    logic [7:0] h2t_q[$];

    always #2.5 clk = ~clk;

    jtag_char_xchg i_jtag_char_xchg (
        .clk(clk), .rst(rst), .sel(sel), .cap_dr(cap_dr), .shift_dr(shift_dr),
        .upd_dr(upd_dr), .tdi(tdi), .tdo(tdo), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_data(rx_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [63:0] gen(input int seed);
        logic [63:0] d;
        for (int k = 0; k < 8; k++) d[k*8 +: 8] = 8'(seed * 37 + k * 11 + 1);
        return d;
    endfunction

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk);
        tx_valid = 1;
        tx_data  = b;
        if (tx_ready) t2h_q.push_back(b);
        @(negedge clk);
        tx_valid = 0;
    endtask

    // one scan frame: header count hdr, data d, nbits shifted, optional trailing 1
    task automatic scan(input int hdr, input logic [63:0] d, input int nbits,
                        input bit extra, input bit selv);
        logic [71:0] out, got;
        int exp_ret, exp_free, take;
        out = {d, 4'(hdr), 4'b0};
        got = '0;
        exp_ret  = (t2h_q.size() > 8) ? 8 : t2h_q.size();
        exp_free = 8 - h2t_q.size();
        @(negedge clk);
        sel = selv;
        cap_dr = 1;
        @(negedge clk);
        cap_dr = 0;
        for (int i = 0; i < nbits; i++) begin
            got[i] = tdo;
            tdi = out[i];
            shift_dr = 1;
            @(negedge clk);
        end
        shift_dr = 0;
        if (extra) begin
            tdi = 1;
            shift_dr = 1;
            @(negedge clk);
            shift_dr = 0;
        end
        upd_dr = 1;
        @(negedge clk);
        upd_dr = 0;
        sel = 1;
        tdi = 0;
        if (selv && nbits >= 8) begin
            chk(int'(got[7:4]) == exp_ret, "R1 returned count", int'(got[7:4]), exp_ret);
            chk(int'(got[3:0]) == exp_free, "R1 free count", int'(got[3:0]), exp_free);
        end
        if (selv && nbits >= 72) begin
            for (int k = 0; k < 8; k++) begin
                int e;
                e = (k < exp_ret) ? int'(t2h_q[k]) : 0;
                chk(int'(got[8 + k*8 +: 8]) == e, "R2 returned slot", int'(got[8 + k*8 +: 8]), e);
            end
            for (int k = 0; k < exp_ret; k++) void'(t2h_q.pop_front());
            take = (hdr < exp_free) ? hdr : exp_free;
            for (int k = 0; k < take; k++) h2t_q.push_back(d[k*8 +: 8]);
        end
    endtask

    task automatic drain(input int exp_n, input string req);
        int n;
        n = 0;
        forever begin
            @(negedge clk);
            if (!rx_valid) break;
            if (h2t_q.size() > 0) begin
                chk(rx_data == h2t_q[0], "R3 byte order", int'(rx_data), int'(h2t_q[0]));
                void'(h2t_q.pop_front());
            end
            rx_ready = 1;
            @(negedge clk);
            rx_ready = 0;
            n++;
        end
        chk(n == exp_n, req, n, exp_n);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!rx_valid, "R8 rx_valid after reset", int'(rx_valid), 0);
        chk(tx_ready, "R8 tx_ready after reset", int'(tx_ready), 1);
        scan(0, gen(1), 72, 0, 1);

        // sweep: prefill level x host count (9..15 clamped via 15)
        for (int pre = 0; pre <= 8; pre++) begin
            for (int j = 0; j <= 10; j++) begin
                int hdr, m;
                hdr = (j == 10) ? 15 : j;
                m = (pre + j) % 9;
                for (int t = 0; t < m; t++) push_tx(8'(pre * 16 + j * 3 + t));
                scan(pre, gen(pre + j), 72, 0, 1);
                scan(hdr, gen(j + 100), 72, bit'(j % 2), 1);
                drain(h2t_q.size(), "R3 pushed count");
                while (t2h_q.size() > 0) scan(0, 64'h0, 72, 0, 1);
            end
        end

        // R7: full target-to-host FIFO refuses further bytes
        for (int t = 0; t < 8; t++) push_tx(8'(200 + t));
        @(negedge clk);
        chk(!tx_ready, "R7 tx_ready low when full", int'(tx_ready), 0);
        push_tx(8'hEE);
        chk(t2h_q.size() == 8, "R7 refused byte", t2h_q.size(), 8);
        scan(0, 64'h0, 72, 0, 1);
        scan(0, 64'h0, 72, 0, 1);

        // R4: update before 72 bits commits nothing
        for (int t = 0; t < 3; t++) push_tx(8'(90 + t));
        scan(2, gen(7), 40, 0, 1);
        @(negedge clk);
        chk(!rx_valid, "R4 early update pushed nothing", int'(rx_valid), 0);
        scan(0, 64'h0, 72, 0, 1);

        // R5: trailing bits ignored, all-ones data
        scan(8, {64{1'b1}}, 72, 1, 1);
        drain(8, "R5 trailing bit ignored");

        // R6: module not selected
        push_tx(8'h31);
        push_tx(8'h32);
        scan(4, gen(9), 72, 0, 0);
        @(negedge clk);
        chk(!rx_valid, "R6 unselected scan pushed nothing", int'(rx_valid), 0);
        chk(t2h_q.size() == 2, "R6 model intact", t2h_q.size(), 2);
        scan(0, 64'h0, 72, 0, 1);

        // R8: reset with data in both FIFOs
        for (int t = 0; t < 3; t++) push_tx(8'(50 + t));
        scan(5, gen(11), 72, 0, 1);
        for (int t = 0; t < 2; t++) push_tx(8'(60 + t));
        @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        t2h_q.delete();
        h2t_q.delete();
        @(negedge clk);
        chk(!rx_valid, "R8 reset empties host-to-target", int'(rx_valid), 0);
        chk(tx_ready, "R8 reset frees target-to-host", int'(tx_ready), 1);
        scan(0, 64'h0, 72, 0, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule